// File: doc/BRIEF.md
# Tag Command Frame Serializer

This block turns a downlink command for a low-frequency tag into an ordered series of symbol requests for a separate symbol timer. The command is described by a control byte, a read/write select, a regular-read flag, a 32-bit data word, a 32-bit password and a block address. The block supports four commands: write, protected write, read and protected read.

On a start pulse the block assembles the complete bit frame for the command. The field order depends on the downlink mode and on the command. It then hands the frame to the timer one request at a time. The timer owns all analog timing. It sees a request line, a symbol kind, a two-bit symbol code and the active downlink mode. It answers each request with a done pulse. Single-bit modes issue one request per frame bit. The one-of-four mode packs consecutive frame bits into two-bit symbols. Each frame opens with a start-gap request, or with a long-reference request followed by the start gap. Each frame closes with a final hold request, which the timer uses for the programming or listening period.

Top module: `cmd_frame_serializer`

## Requirements
- R1: After reset `busy_o` and `sym_req_o` are both low.
- R2: Control byte fields: bit 0 enables the password, bit 1 is the page, bit 2 is test mode, and bits 4:3 are the downlink mode (0 fixed-length bits, 1 long reference, 2 leading zero, 3 one-of-four). `sym_mode_o` shows the latched mode for the whole frame.
- R3: Symbol kinds: 0 start gap, 1 long reference, 2 single bit, 3 bit pair, 4 final hold. A frame opens with kind 0. In mode 1 a kind 1 request comes first and then kind 0. The last request is kind 4, and bit 0 of its code is 1 for a write and 0 for a read.
- R4: The opcode is a 1 followed by the page bit. A write in test mode sends 0 then 1 instead. Reads ignore test mode.
- R5: With the password enabled, two 0 bits follow the opcode, then the 32 password bits with the most significant bit first. Without it, neither is sent.
- R6: A write then sends a 0 lock bit, then the 32 data bits MSB first, then the 3 address bits MSB first.
- R7: A read then sends one 0 separator bit, followed by the 3 address bits MSB first unless the regular-read flag is set.
- R8: In modes 0, 1 and 2 each frame bit is one kind 2 request with code {0, bit}. Mode 2 inserts one 0 bit before the opcode.
- R9: In mode 3 a 00 reference pair comes before the opcode. The stream bits are grouped in order into kind 3 requests with code {earlier bit, later bit}. As a result the lock bit pairs with data bit 31, and data bit 0 pairs with address bit 2. A final unpaired bit is not sent.
- R10: A request keeps its kind, code and mode steady until `sym_done_i` is sampled high. The next request appears on the following cycle.
- R11: `busy_o` rises on the cycle after an accepted start and falls on the cycle after the final hold is acknowledged. A start while busy is ignored.
- R12: Only the low 3 bits of the address input are sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a command frame |
| ctrl_i | input | 8 | Control byte |
| wr_i | input | 1 | 1 write, 0 read |
| regread_i | input | 1 | Read without block address |
| data_i | input | 32 | Data word for writes |
| pwd_i | input | 32 | Password |
| addr_i | input | 8 | Block address (masked to 3 bits) |
| sym_done_i | input | 1 | Timer finished the current request |
| sym_req_o | output | 1 | Symbol request pending |
| sym_kind_o | output | 3 | Kind of the requested symbol |
| sym_code_o | output | 2 | Symbol value |
| sym_mode_o | output | 2 | Downlink mode of the frame |
| busy_o | output | 1 | Frame in progress |

## Verification
The bench targets the places where fields shift against each other.

- One-of-four writes, where the lock bit pushes the data off pair boundaries. A design that restarted pairing at the data field would send a wrong pair holding data bit 31.
- One-of-four regular reads, whose odd bit count would leave a stray half symbol if the trailing bit were not dropped.
- Test-mode reads, which must keep the normal opcode.
- Mid-frame starts, which must not disturb the running frame.
- A timer that holds done low, during which a careless design would advance or change the symbol it shows.

// File: rtl/cmd_frame_pkg.sv
package cmd_frame_pkg;

   typedef enum logic [1:0] {
      DL_FIXED   = 2'd0,
      DL_LONGREF = 2'd1,
      DL_LEADZ   = 2'd2,
      DL_QUAD    = 2'd3
   } dl_mode_e;

   typedef enum logic [2:0] {
      SK_GAP  = 3'd0,
      SK_LREF = 3'd1,
      SK_BIT  = 3'd2,
      SK_PAIR = 3'd3,
      SK_HOLD = 3'd4
   } sym_kind_e;

   localparam int unsigned CB_PWD    = 0;
   localparam int unsigned CB_PAGE   = 1;
   localparam int unsigned CB_TEST   = 2;
   localparam int unsigned CB_MODE_L = 3;
   localparam int unsigned CB_MODE_H = 4;

endpackage

// File: rtl/cmd_frame_builder.sv
module cmd_frame_builder
   import cmd_frame_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned PWD_W   = 32,
   parameter int unsigned ADDR_W  = 3,
   parameter int unsigned FRAME_W = 74,
   parameter int unsigned CNT_W   = 7
) (
   input  dl_mode_e             mode_i,
   input  logic                 pwd_en_i,
   input  logic                 page_i,
   input  logic                 test_i,
   input  logic                 wr_i,
   input  logic                 regread_i,
   input  logic [DATA_W-1:0]    data_i,
   input  logic [PWD_W-1:0]     pwd_i,
   input  logic [ADDR_W-1:0]    addr_i,
   output logic [FRAME_W-1:0]   frame_o,
   output logic [CNT_W-1:0]     nbits_o
);

   localparam int unsigned NEED_W = 6 + PWD_W + 1 + DATA_W + ADDR_W;

   if (FRAME_W < NEED_W) begin : g_bad_frame
      $error("cmd_frame_builder: FRAME_W too small");
   end
   if ((1 << CNT_W) <= FRAME_W) begin : g_bad_cnt
      $error("cmd_frame_builder: CNT_W too small");
   end

   logic [1:0] opcode;

   // Frame is right-aligned, oldest bit at the highest occupied position.
   always_comb begin
      opcode  = (wr_i && test_i) ? 2'b01 : {1'b1, page_i};
      frame_o = '0;
      nbits_o = '0;
      if (mode_i == DL_LEADZ) begin
         frame_o = frame_o << 1;
         nbits_o = nbits_o + CNT_W'(1);
      end
      if (mode_i == DL_QUAD) begin
         frame_o = frame_o << 2;
         nbits_o = nbits_o + CNT_W'(2);
      end
      frame_o = (frame_o << 2) | FRAME_W'(opcode);
      nbits_o = nbits_o + CNT_W'(2);
      if (pwd_en_i) begin
         frame_o = frame_o << 2;
         frame_o = (frame_o << PWD_W) | FRAME_W'(pwd_i);
         nbits_o = nbits_o + CNT_W'(2 + PWD_W);
      end
      // lock bit for writes, separator bit for reads: both zero
      frame_o = frame_o << 1;
      nbits_o = nbits_o + CNT_W'(1);
      if (wr_i) begin
         frame_o = (frame_o << DATA_W) | FRAME_W'(data_i);
         nbits_o = nbits_o + CNT_W'(DATA_W);
      end
      if (wr_i || !regread_i) begin
         frame_o = (frame_o << ADDR_W) | FRAME_W'(addr_i);
         nbits_o = nbits_o + CNT_W'(ADDR_W);
      end
   end

endmodule

// File: rtl/cmd_symbol_seq.sv
module cmd_symbol_seq
   import cmd_frame_pkg::*;
#(
   parameter int unsigned FRAME_W = 74,
   parameter int unsigned CNT_W   = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [FRAME_W-1:0] frame_i,
   input  logic [CNT_W-1:0]   nbits_i,
   input  dl_mode_e           mode_i,
   input  logic               wr_i,
   input  logic               sym_done_i,
   output logic               sym_req_o,
   output sym_kind_e          sym_kind_o,
   output logic [1:0]         sym_code_o,
   output dl_mode_e           sym_mode_o,
   output logic               busy_o
);

   typedef enum logic [2:0] {
      ST_IDLE, ST_LREF, ST_GAP, ST_SYM, ST_HOLD
   } seq_state_e;

   seq_state_e         state_q;
   logic [FRAME_W-1:0] frame_q;
   logic [CNT_W-1:0]   left_q;
   dl_mode_e           mode_q;
   logic               wr_q;
   logic               quad;
   logic               ack;

   assign quad = (mode_q == DL_QUAD);
   assign ack  = sym_req_o && sym_done_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         frame_q <= '0;
         left_q  <= '0;
         mode_q  <= DL_FIXED;
         wr_q    <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: if (start_i) begin
               frame_q <= frame_i << (CNT_W'(FRAME_W) - nbits_i);
               left_q  <= nbits_i;
               mode_q  <= mode_i;
               wr_q    <= wr_i;
               state_q <= (mode_i == DL_LONGREF) ? ST_LREF : ST_GAP;
            end
            ST_LREF: if (ack) state_q <= ST_GAP;
            ST_GAP:  if (ack) state_q <= ST_SYM;
            ST_SYM: if (ack) begin
               if (quad) begin
                  frame_q <= frame_q << 2;
                  left_q  <= left_q - CNT_W'(2);
                  if (left_q < CNT_W'(4)) state_q <= ST_HOLD;
               end else begin
                  frame_q <= frame_q << 1;
                  left_q  <= left_q - CNT_W'(1);
                  if (left_q == CNT_W'(1)) state_q <= ST_HOLD;
               end
            end
            ST_HOLD: if (ack) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      sym_kind_o = SK_GAP;
      sym_code_o = 2'b00;
      case (state_q)
         ST_LREF: sym_kind_o = SK_LREF;
         ST_SYM: begin
            if (quad) begin
               sym_kind_o = SK_PAIR;
               sym_code_o = frame_q[FRAME_W-1 -: 2];
            end else begin
               sym_kind_o = SK_BIT;
               sym_code_o = {1'b0, frame_q[FRAME_W-1]};
            end
         end
         ST_HOLD: begin
            sym_kind_o = SK_HOLD;
            sym_code_o = {1'b0, wr_q};
         end
         default: ;
      endcase
   end

   assign sym_req_o  = (state_q != ST_IDLE);
   assign busy_o     = (state_q != ST_IDLE);
   assign sym_mode_o = mode_q;

endmodule

// File: rtl/cmd_frame_serializer.sv
module cmd_frame_serializer
   import cmd_frame_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned PWD_W     = 32,
   parameter int unsigned ADDR_W    = 3,
   parameter int unsigned ADDR_IN_W = 8,
   parameter int unsigned CTRL_W    = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic [CTRL_W-1:0]    ctrl_i,
   input  logic                 wr_i,
   input  logic                 regread_i,
   input  logic [DATA_W-1:0]    data_i,
   input  logic [PWD_W-1:0]     pwd_i,
   input  logic [ADDR_IN_W-1:0] addr_i,
   input  logic                 sym_done_i,
   output logic                 sym_req_o,
   output logic [2:0]           sym_kind_o,
   output logic [1:0]           sym_code_o,
   output logic [1:0]           sym_mode_o,
   output logic                 busy_o
);

   localparam int unsigned FRAME_W = 6 + PWD_W + 1 + DATA_W + ADDR_W;
   localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);

   if (ADDR_IN_W < ADDR_W) begin : g_bad_addr
      $error("cmd_frame_serializer: ADDR_IN_W below ADDR_W");
   end
   if (CTRL_W <= CB_MODE_H) begin : g_bad_ctrl
      $error("cmd_frame_serializer: CTRL_W too narrow");
   end

   logic [ADDR_W-1:0] addr_m;
   assign addr_m = addr_i[ADDR_W-1:0];

   if (ADDR_IN_W > ADDR_W) begin : g_addr_wide
      logic addr_hi_unused;
      assign addr_hi_unused = ^addr_i[ADDR_IN_W-1:ADDR_W];
   end
   if (CTRL_W > CB_MODE_H + 1) begin : g_ctrl_wide
      logic ctrl_hi_unused;
      assign ctrl_hi_unused = ^ctrl_i[CTRL_W-1:CB_MODE_H+1];
   end

   dl_mode_e           mode_in;
   logic [FRAME_W-1:0] frame;
   logic [CNT_W-1:0]   nbits;
   sym_kind_e          kind;
   dl_mode_e           mode_out;

   assign mode_in = dl_mode_e'(ctrl_i[CB_MODE_H:CB_MODE_L]);

   cmd_frame_builder #(
      .DATA_W (DATA_W), .PWD_W (PWD_W), .ADDR_W (ADDR_W),
      .FRAME_W(FRAME_W), .CNT_W (CNT_W)
   ) u_build (
      .mode_i    (mode_in),
      .pwd_en_i  (ctrl_i[CB_PWD]),
      .page_i    (ctrl_i[CB_PAGE]),
      .test_i    (ctrl_i[CB_TEST]),
      .wr_i      (wr_i),
      .regread_i (regread_i),
      .data_i    (data_i),
      .pwd_i     (pwd_i),
      .addr_i    (addr_m),
      .frame_o   (frame),
      .nbits_o   (nbits)
   );

   cmd_symbol_seq #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .frame_i    (frame),
      .nbits_i    (nbits),
      .mode_i     (mode_in),
      .wr_i       (wr_i),
      .sym_done_i (sym_done_i),
      .sym_req_o  (sym_req_o),
      .sym_kind_o (kind),
      .sym_code_o (sym_code_o),
      .sym_mode_o (mode_out),
      .busy_o     (busy_o)
   );

   assign sym_kind_o = kind;
   assign sym_mode_o = mode_out;

endmodule

// File: rtl/cmd_frame_serializer_chk.sv
module cmd_frame_serializer_chk
   import cmd_frame_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       start_i,
   input logic [7:0] ctrl_i,
   input logic       sym_done_i,
   input logic       sym_req_o,
   input logic [2:0] sym_kind_o,
   input logic [1:0] sym_code_o,
   input logic [1:0] sym_mode_o,
   input logic       busy_o
);

   // R10: request content frozen until acknowledged
   a_r10_hold_until_done: assert property (@(posedge clk) disable iff (!rst_n)
      sym_req_o && !sym_done_i |=> sym_req_o && $stable(sym_kind_o)
                                   && $stable(sym_code_o) && $stable(sym_mode_o));

   // R11: frame keeps running and mode is kept whatever happens on start_i
   a_r11_busy_persists: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && !(sym_done_i && sym_kind_o == SK_HOLD) |=> busy_o && $stable(sym_mode_o));

   // R11: acknowledged final hold ends the frame
   a_r11_hold_ends: assert property (@(posedge clk) disable iff (!rst_n)
      sym_req_o && sym_done_i && sym_kind_o == SK_HOLD |=> !busy_o);

   // R3: first request of a frame
   a_r3_first_symbol: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o && start_i |=> sym_req_o &&
         (sym_kind_o == (($past(ctrl_i[4:3]) == DL_LONGREF) ? SK_LREF : SK_GAP)));

   // R3: long reference is followed by the start gap
   a_r3_lref_then_gap: assert property (@(posedge clk) disable iff (!rst_n)
      sym_req_o && sym_done_i && sym_kind_o == SK_LREF |=> sym_kind_o == SK_GAP);

   // R9: pairs only in one-of-four mode
   a_r9_pair_only_quad: assert property (@(posedge clk) disable iff (!rst_n)
      sym_req_o && sym_kind_o == SK_PAIR |-> sym_mode_o == DL_QUAD);

   // R8: single bits never in one-of-four mode
   a_r8_bit_not_quad: assert property (@(posedge clk) disable iff (!rst_n)
      sym_req_o && sym_kind_o == SK_BIT |-> sym_mode_o != DL_QUAD && !sym_code_o[1]);

   // R1: no request without a frame in progress
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !sym_req_o);

endmodule

bind cmd_frame_serializer cmd_frame_serializer_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .ctrl_i     (ctrl_i),
   .sym_done_i (sym_done_i),
   .sym_req_o  (sym_req_o),
   .sym_kind_o (sym_kind_o),
   .sym_code_o (sym_code_o),
   .sym_mode_o (sym_mode_o),
   .busy_o     (busy_o)
);

// File: tb/sim_cmd_frame_serializer.sv
module sim_cmd_frame_serializer;

   typedef struct packed {
      logic [7:0]  ctrl;
      logic        wr;
      logic        rr;
      logic [31:0] data;
      logic [31:0] pwd;
      logic [7:0]  addr;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VECS [NV] = '{
      '{8'h00, 1'b1, 1'b0, 32'hA5C3_0F96, 32'h0000_0000, 8'h03},
      '{8'h03, 1'b1, 1'b0, 32'h1234_5678, 32'hDEAD_BEEF, 8'h06},
      '{8'h04, 1'b1, 1'b0, 32'hFFFF_0000, 32'h0000_0000, 8'h01},
      '{8'h11, 1'b1, 1'b0, 32'h0F0F_F0F0, 32'h8000_0001, 8'h02},
      '{8'h19, 1'b1, 1'b0, 32'hC001_D00D, 32'h7654_3210, 8'h04},
      '{8'h18, 1'b1, 1'b0, 32'h8000_0001, 32'h0000_0000, 8'h05},
      '{8'h08, 1'b0, 1'b0, 32'h0000_0000, 32'h0000_0000, 8'h07},
      '{8'h02, 1'b0, 1'b1, 32'h0000_0000, 32'h0000_0000, 8'h06},
      '{8'h19, 1'b0, 1'b1, 32'h0000_0000, 32'hABCD_1234, 8'h03},
      '{8'h1C, 1'b0, 1'b0, 32'h0000_0000, 32'h0000_0000, 8'h06},
      '{8'h12, 1'b0, 1'b0, 32'h0000_0000, 32'h0000_0000, 8'hFD}
   };

   function automatic string tag_of(int i);
      case (i)
         0: return "R6 R8 fixed write";
         1: return "R5 R2 fixed protected write page1";
         2: return "R4 test-mode write";
         3: return "R8 leading-zero protected write";
         4: return "R9 one-of-four protected write";
         5: return "R9 one-of-four lock pairing";
         6: return "R3 R7 long-reference read";
         7: return "R7 regular read";
         8: return "R9 one-of-four regular read drop";
         9: return "R4 one-of-four read ignores test";
         default: return "R12 leading-zero read masked address";
      endcase
   endfunction

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [7:0]  ctrl_i = '0;
   logic        wr_i = 1'b0;
   logic        regread_i = 1'b0;
   logic [31:0] data_i = '0;
   logic [31:0] pwd_i = '0;
   logic [7:0]  addr_i = '0;
   logic        sym_done_i = 1'b0;
   logic        sym_req_o;
   logic [2:0]  sym_kind_o;
   logic [1:0]  sym_code_o;
   logic [1:0]  sym_mode_o;
   logic        busy_o;

   always #10 clk = ~clk;

   cmd_frame_serializer u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .ctrl_i(ctrl_i),
      .wr_i(wr_i), .regread_i(regread_i), .data_i(data_i), .pwd_i(pwd_i),
      .addr_i(addr_i), .sym_done_i(sym_done_i), .sym_req_o(sym_req_o),
      .sym_kind_o(sym_kind_o), .sym_code_o(sym_code_o),
      .sym_mode_o(sym_mode_o), .busy_o(busy_o)
   );

   int n_run = 0;
   int n_fail = 0;
   bit done_all = 1'b0;
   bit resp_en = 1'b1;

   logic [2:0] got_k[$];
   logic [1:0] got_c[$];
   logic [2:0] exp_k[$];
   logic [1:0] exp_c[$];

   task automatic chk(bit ok, string tag, string what, int act, int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // timer model: acknowledge each request one cycle after seeing it
   initial begin
      forever begin
         @(negedge clk);
         if (resp_en && sym_req_o && !sym_done_i) begin
            got_k.push_back(sym_kind_o);
            got_c.push_back(sym_code_o);
            sym_done_i = 1'b1;
         end else begin
            sym_done_i = 1'b0;
         end
      end
   end

   function automatic void build_exp(vec_t v);
      bit b[$];
      logic [1:0] m;
      m = v.ctrl[4:3];
      exp_k.delete();
      exp_c.delete();
      if (m == 2'd1) begin exp_k.push_back(3'd1); exp_c.push_back(2'd0); end
      exp_k.push_back(3'd0); exp_c.push_back(2'd0);
      if (m == 2'd2) b.push_back(1'b0);
      if (m == 2'd3) begin b.push_back(1'b0); b.push_back(1'b0); end
      if (v.wr && v.ctrl[2]) begin
         b.push_back(1'b0); b.push_back(1'b1);
      end else begin
         b.push_back(1'b1); b.push_back(v.ctrl[1]);
      end
      if (v.ctrl[0]) begin
         b.push_back(1'b0); b.push_back(1'b0);
         for (int i = 31; i >= 0; i--) b.push_back(v.pwd[i]);
      end
      b.push_back(1'b0);
      if (v.wr) for (int i = 31; i >= 0; i--) b.push_back(v.data[i]);
      if (v.wr || !v.rr) for (int i = 2; i >= 0; i--) b.push_back(v.addr[i]);
      if (m == 2'd3) begin
         for (int i = 0; i + 1 < b.size(); i += 2) begin
            exp_k.push_back(3'd3); exp_c.push_back({b[i], b[i+1]});
         end
      end else begin
         for (int i = 0; i < b.size(); i++) begin
            exp_k.push_back(3'd2); exp_c.push_back({1'b0, b[i]});
         end
      end
      exp_k.push_back(3'd4); exp_c.push_back({1'b0, v.wr});
   endfunction

   task automatic apply(vec_t v);
      ctrl_i = v.ctrl; wr_i = v.wr; regread_i = v.rr;
      data_i = v.data; pwd_i = v.pwd; addr_i = v.addr;
   endtask

   task automatic wait_idle();
      int guard;
      guard = 0;
      while (busy_o && guard < 3000) begin
         @(negedge clk);
         guard++;
      end
      @(negedge clk);
   endtask

   task automatic compare(string tag);
      int bad;
      bad = -1;
      chk(got_k.size() == exp_k.size(), tag, "symbol count", got_k.size(), exp_k.size());
      for (int i = 0; i < exp_k.size() && i < got_k.size(); i++)
         if (bad < 0 && (got_k[i] != exp_k[i] || got_c[i] != exp_c[i])) bad = i;
      if (bad >= 0)
         chk(1'b0, tag, $sformatf("symbol %0d kind*4+code", bad),
             got_k[bad]*4 + got_c[bad], exp_k[bad]*4 + exp_c[bad]);
      else
         chk(1'b1, tag, "sequence", 0, 0);
   endtask

   task automatic pulse_start();
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(busy_o == 1'b0, "R1", "busy after reset", busy_o, 0);
      chk(sym_req_o == 1'b0, "R1", "req after reset", sym_req_o, 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         apply(VECS[i]);
         build_exp(VECS[i]);
         got_k.delete(); got_c.delete();
         pulse_start();
         chk(busy_o == 1'b1, tag_of(i), "busy after start", busy_o, 1);
         chk(sym_mode_o == VECS[i].ctrl[4:3], tag_of(i), "R2 mode shown",
             sym_mode_o, VECS[i].ctrl[4:3]);
         wait_idle();
         compare(tag_of(i));
      end

      // R11: start while busy is ignored
      apply(VECS[0]);
      build_exp(VECS[0]);
      got_k.delete(); got_c.delete();
      pulse_start();
      repeat (6) @(negedge clk);
      apply(VECS[8]);
      pulse_start();
      chk(sym_mode_o == 2'd0, "R11", "mode after ignored start", sym_mode_o, 0);
      apply(VECS[0]);
      wait_idle();
      compare("R11 start while busy");
      chk(busy_o == 1'b0, "R11", "busy dropped after hold", busy_o, 0);

      // R10: timer stalls, request must stay put
      resp_en = 1'b0;
      apply(VECS[6]);
      build_exp(VECS[6]);
      got_k.delete(); got_c.delete();
      pulse_start();
      repeat (5) @(negedge clk);
      chk(sym_req_o == 1'b1, "R10", "req held during stall", sym_req_o, 1);
      chk(sym_kind_o == 3'd1, "R10", "kind held during stall", sym_kind_o, 1);
      resp_en = 1'b1;
      wait_idle();
      compare("R10 stalled handshake");

      done_all = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done_all) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: run did not finish actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule